// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the home-node controller for a small shared-memory system of caching processors. For every memory block it holds a directory entry made of one presence bit per processor and one dirty bit. Caches send it two kinds of request: a read miss, which returns the block's data, and a write-permission request, which returns a grant once no other cache can still hold a copy. The controller never broadcasts. It sends an invalidation or a fetch only to the processors whose presence bits are set, and it counts their responses before it answers the requester.

All traffic uses one-cycle valid/ready channels. One channel carries requests in. One carries messages out (invalidate, fetch, read data, write grant). One carries cache responses back, and those responses can include a written-back data word. The controller serves one transaction at a time. While a transaction is open, requests are held off by keeping the request ready signal low. This serialises all traffic to a block, including the case where a write is waiting for acknowledgements. A small memory array holds the data word for each block.

Top module: `dir_ctrl`

## Requirements
- R1: After synchronous active-low reset every directory entry has no presence bits and a clear dirty bit, memory block b holds the value b, `req_ready` is high, and `out_valid` and `rsp_ready` are low.
- R2: A read miss to a clean block produces exactly one message: kind 2 (data) to the requester, carrying the block's memory word. The requester's presence bit is then set.
- R3: A write-permission request sends one kind 0 (invalidate) message to each processor recorded as a sharer other than the requester, lowest processor index first, one per out-channel handshake. No other processor is sent a message, and an offered message holds its destination and kind until it is taken.
- R4: The kind 3 (grant) to the requester is sent only after responses from every invalidated processor have been accepted. It carries the block's current memory word.
- R5: After a grant the entry records only the writer's presence bit and sets the dirty bit, so a later request that must reach the copies contacts the writer alone.
- R6: A read miss to a dirty block first sends kind 1 (fetch) to the owner and waits for its response. A response with `rsp_wb` high writes `rsp_data` to memory, and the data reply carries that word. The dirty bit is then cleared, and both the owner and the reader stay recorded.
- R7: While a transaction is open (fan-out, waiting for responses, or replying), `req_ready` stays low, and a new request is taken only after the reply has been accepted.
- R8: An invalidation response with `rsp_wb` high (from the owner of a dirty block) also writes `rsp_data` to memory before the grant, and the grant carries that word.
- R9: `rsp_ready` is high only while at least one response is outstanding, and the outstanding count never exceeds the number of processors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write permission, 0 = read miss |
| req_src | input | 2 | Requesting processor |
| req_blk | input | 4 | Block index |
| out_valid | output | 1 | Outgoing message offered |
| out_ready | input | 1 | Network takes the outgoing message |
| out_kind | output | 2 | 0 invalidate, 1 fetch, 2 read data, 3 write grant |
| out_dst | output | 2 | Destination processor |
| out_blk | output | 4 | Block the message refers to |
| out_data | output | 8 | Data word for kinds 2 and 3 |
| rsp_valid | input | 1 | Cache response offered |
| rsp_ready | output | 1 | Controller takes the response |
| rsp_src | input | 2 | Responding processor |
| rsp_wb | input | 1 | Response carries written-back data |
| rsp_data | input | 8 | Written-back data word |

## Verification
The bench targets four cases: a write issued by a block's own sharer, a write to a block owned dirty by another processor, a read by a third processor after a write, and a repeated write by the current owner. A controller that invalidated the requester would send it an extra kind 0 message. One that dropped the owner's written-back word would return stale data in the reply. One that kept old sharers after a grant would send more fetches than expected. Responses are delayed at random and the out channel is stalled at random, so a grant issued before the last acknowledgement, or a message that changes while stalled, shows up as a wrong ordering or a wrong destination.

// File: rtl/dir_pkg.sv
// Shared types for the directory controller: message kinds and controller states.
package dir_pkg;
    typedef enum logic [1:0] {
        MSG_INV   = 2'd0,
        MSG_FETCH = 2'd1,
        MSG_DATA  = 2'd2,
        MSG_GRANT = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XACT  = 2'd1,
        ST_REPLY = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/dir_store.sv
// Directory entries and block data. There is one register set per block, built by generate.
// Assumes: one entry write and one memory write per cycle at most; reads are combinational.
module dir_store #(
    parameter int NPROC  = 4,
    parameter int NBLK   = 16,
    parameter int DATA_W = 8,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  rd_blk,
    output logic [NPROC-1:0]  rd_pres,
    output logic              rd_dirty,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ent_we,
    input  logic [BLK_W-1:0]  ent_blk,
    input  logic [NPROC-1:0]  ent_pres,
    input  logic              ent_dirty,
    input  logic              mem_we,
    input  logic [BLK_W-1:0]  mem_blk,
    input  logic [DATA_W-1:0] mem_wdata
);
    logic [NBLK*NPROC-1:0]  pres_all;
    logic [NBLK-1:0]        dirty_all;
    logic [NBLK*DATA_W-1:0] data_all;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [NPROC-1:0]  pres_r;
        logic              dirty_r;
        logic [DATA_W-1:0] data_r;

        // Entry state for block g: cleared at reset, replaced on an entry write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_r  <= '0;
                dirty_r <= 1'b0;
            end else if (ent_we && ent_blk == BLK_W'(g)) begin
                pres_r  <= ent_pres;
                dirty_r <= ent_dirty;
            end
        end

        // Data word for block g: preset to its index, written on a writeback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_r <= DATA_W'(g);
            end else if (mem_we && mem_blk == BLK_W'(g)) begin
                data_r <= mem_wdata;
            end
        end

        assign pres_all[g*NPROC +: NPROC]   = pres_r;
        assign dirty_all[g]                 = dirty_r;
        assign data_all[g*DATA_W +: DATA_W] = data_r;
    end

    assign rd_pres  = pres_all[rd_blk*NPROC +: NPROC];
    assign rd_dirty = dirty_all[rd_blk];
    assign rd_data  = data_all[rd_blk*DATA_W +: DATA_W];
endmodule

// File: rtl/dir_fanout.sv
// Target mask and response counter for one transaction. It picks the lowest pending target,
// clears it when its message is taken, and counts messages sent minus responses accepted.
// Assumes: load happens only when no transaction is open.
module dir_fanout #(
    parameter int NPROC  = 4,
    parameter int CNT_W  = 6,
    localparam int SRC_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             send_fire,
    input  logic             ack_fire,
    output logic             pend_any,
    output logic [SRC_W-1:0] pick_idx,
    output logic [CNT_W-1:0] ack_cnt,
    output logic             all_done
);
    logic [NPROC-1:0] mask_q;

    // Lowest-index pending target.
    always_comb begin
        pick_idx = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (mask_q[i]) pick_idx = SRC_W'(i);
        end
    end

    assign pend_any = |mask_q;
    assign all_done = !pend_any && (ack_cnt == '0);

    // Target mask: loaded per transaction, one bit retired per message sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= load_mask;
        end else if (send_fire) begin
            mask_q <= mask_q & ~(NPROC'(1) << pick_idx);
        end
    end

    // Outstanding responses: up on each message sent, down on each response taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_cnt <= '0;
        end else begin
            ack_cnt <= ack_cnt + CNT_W'(send_fire) - CNT_W'(ack_fire);
        end
    end
endmodule

// File: rtl/dir_ctrl.sv
// Home directory controller, top level. It serves one request at a time: looks up the entry,
// sends invalidations or a fetch to the recorded copies, waits for all responses,
// then replies and updates the entry. Assumes responses arrive only from contacted processors.
module dir_ctrl #(
    parameter int NPROC  = 4,
    parameter int NBLK   = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6,
    localparam int SRC_W = $clog2(NPROC),
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [SRC_W-1:0]  out_dst,
    output logic [BLK_W-1:0]  out_blk,
    output logic [DATA_W-1:0] out_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [SRC_W-1:0]  rsp_src,
    input  logic              rsp_wb,
    input  logic [DATA_W-1:0] rsp_data
);
    import dir_pkg::*;

    ctl_state_e        state_q;
    logic [SRC_W-1:0]  cur_src;
    logic [BLK_W-1:0]  cur_blk;
    logic              cur_write;

    logic [BLK_W-1:0]  rd_blk;
    logic [NPROC-1:0]  rd_pres;
    logic              rd_dirty;
    logic [DATA_W-1:0] rd_data;
    logic              ent_we;
    logic [NPROC-1:0]  ent_pres;
    logic              ent_dirty;

    logic              req_fire, out_fire, ack_fire, send_fire;
    logic [NPROC-1:0]  load_mask;
    logic              pend_any, all_done;
    logic [SRC_W-1:0]  pick_idx;
    logic [CNT_W-1:0]  ack_cnt;
    msg_kind_e         kind_c;

    // The rsp_src field is not used: the counter relies on responses coming from contacted caches.
    logic unused_src;
    assign unused_src = ^rsp_src;

    assign rd_blk    = (state_q == ST_IDLE) ? req_blk : cur_blk;
    assign req_ready = (state_q == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign out_fire  = out_valid && out_ready;
    assign rsp_ready = (state_q == ST_XACT) && (ack_cnt != '0);
    assign ack_fire  = rsp_valid && rsp_ready;
    assign send_fire = (state_q == ST_XACT) && out_fire;

    // Targets: writes reach every sharer but the writer; reads reach the owner of a dirty block.
    always_comb begin
        if (req_write) begin
            load_mask = rd_pres & ~(NPROC'(1) << req_src);
        end else if (rd_dirty) begin
            load_mask = rd_pres;
        end else begin
            load_mask = '0;
        end
    end

    // Outgoing message: fan-out while the transaction is open, then the reply to the requester.
    always_comb begin
        out_valid = 1'b0;
        kind_c    = MSG_INV;
        out_dst   = pick_idx;
        if (state_q == ST_XACT) begin
            out_valid = pend_any;
            kind_c    = cur_write ? MSG_INV : MSG_FETCH;
        end else if (state_q == ST_REPLY) begin
            out_valid = 1'b1;
            kind_c    = cur_write ? MSG_GRANT : MSG_DATA;
            out_dst   = cur_src;
        end
    end
    assign out_kind = kind_c;
    assign out_blk  = cur_blk;
    assign out_data = rd_data;

    // Entry update when the reply is taken: writer alone and dirty, or reader added and clean.
    always_comb begin
        ent_we = (state_q == ST_REPLY) && out_fire;
        if (cur_write) begin
            ent_pres  = NPROC'(1) << cur_src;
            ent_dirty = 1'b1;
        end else begin
            ent_pres  = rd_pres | (NPROC'(1) << cur_src);
            ent_dirty = 1'b0;
        end
    end

    // Transaction sequencing: idle, fan-out and response wait, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_src   <= '0;
            cur_blk   <= '0;
            cur_write <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_fire) begin
                    state_q   <= ST_XACT;
                    cur_src   <= req_src;
                    cur_blk   <= req_blk;
                    cur_write <= req_write;
                end
                ST_XACT:  if (all_done) state_q <= ST_REPLY;
                ST_REPLY: if (out_fire) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_blk    (rd_blk),
        .rd_pres   (rd_pres),
        .rd_dirty  (rd_dirty),
        .rd_data   (rd_data),
        .ent_we    (ent_we),
        .ent_blk   (cur_blk),
        .ent_pres  (ent_pres),
        .ent_dirty (ent_dirty),
        .mem_we    (ack_fire && rsp_wb),
        .mem_blk   (cur_blk),
        .mem_wdata (rsp_data)
    );

    dir_fanout #(.NPROC(NPROC), .CNT_W(CNT_W)) u_fanout (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (req_fire),
        .load_mask (load_mask),
        .send_fire (send_fire),
        .ack_fire  (ack_fire),
        .pend_any  (pend_any),
        .pick_idx  (pick_idx),
        .ack_cnt   (ack_cnt),
        .all_done  (all_done)
    );
endmodule

// File: rtl/dir_ctrl_chk.sv
// Protocol checker for dir_ctrl, attached by bind. It observes ports and the fan-out counter.
module dir_ctrl_chk #(
    parameter int NPROC = 4,
    parameter int CNT_W = 6,
    localparam int SRC_W = $clog2(NPROC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_kind,
    input logic [SRC_W-1:0] out_dst,
    input logic             rsp_ready,
    input logic [CNT_W-1:0] ack_cnt,
    input logic             pend_any
);
    // R7: no request is taken while responses are outstanding.
    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cnt != '0) |-> !req_ready);

    // R4: a grant is offered only once all targets are contacted and all responses are in.
    assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd3) |-> (ack_cnt == '0 && !pend_any));

    // R3: an offered message holds its destination and kind until it is taken.
    assert_msg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dst) && $stable(out_kind)));

    // R9: responses are taken only while some are outstanding.
    assert_rsp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (ack_cnt != '0));

    // R9: the outstanding count never exceeds the number of processors.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cnt <= CNT_W'(NPROC));

    // R5: once a reply is taken, the controller is free for the next request.
    assert_reply_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_kind[1]) |=> req_ready);
endmodule

bind dir_ctrl dir_ctrl_chk #(.NPROC(NPROC), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_dst   (out_dst),
    .rsp_ready (rsp_ready),
    .ack_cnt   (ack_cnt),
    .pend_any  (pend_any)
);

// File: tb/dir_ctrl_tb.sv
// Bench for dir_ctrl: directed corner cases, then seeded random traffic, checked against a model.
module dir_ctrl_tb;
    localparam int NP = 4;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_src = '0;
    logic [3:0] req_blk = '0;
    logic       out_ready = 1'b1;
    logic       rsp_valid = 1'b0, rsp_wb = 1'b0;
    logic [1:0] rsp_src = '0;
    logic [7:0] rsp_data = '0;
    logic       req_ready, out_valid, rsp_ready;
    logic [1:0] out_kind, out_dst;
    logic [3:0] out_blk;
    logic [7:0] out_data;

    int n_chk = 0, n_fail = 0;
    int last_nmsg;
    logic [3:0] m_pres [NB];
    logic       m_dirty [NB];
    logic [7:0] m_mem [NB];
    logic [7:0] m_cval [NP][NB];

    always #5 clk = ~clk;

    dir_ctrl u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] m);
        for (int i = NP - 1; i >= 0; i--) if (m[i]) lowest = i;
        if (m == 0) lowest = -1;
    endfunction

    task automatic run_req(input int src, input bit wr, input int blk);
        logic [3:0] exp_mask, pend;
        bit done = 0, had_wb = 0, stall_bad = 0, was_dirty;
        int cycles = 0, nmsg = 0, owner;
        string dtag;
        was_dirty = m_dirty[blk];
        owner = lowest(m_pres[blk]);
        exp_mask = wr ? (m_pres[blk] & ~(4'(1) << src)) : (was_dirty ? m_pres[blk] : 4'd0);
        pend = 0;
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_src = 2'(src); req_blk = 4'(blk);
        @(negedge clk);
        chk(req_ready == 1, "R7", "ready when idle", int'(req_ready), 1);
        @(posedge clk); #1;
        req_valid = 0;
        while (!done) begin
            bit hs_o, hs_r;
            @(negedge clk);
            cycles++;
            if (req_ready) stall_bad = 1;
            hs_o = out_valid && out_ready;
            hs_r = rsp_valid && rsp_ready;
            if (hs_o) begin
                if (out_kind < 2) begin
                    int e = lowest(exp_mask);
                    chk(int'(out_kind) == (wr ? 0 : 1), wr ? "R3" : "R6", "fan-out kind", int'(out_kind), wr ? 0 : 1);
                    chk(int'(out_dst) == e, wr ? "R3" : "R6", "fan-out target", int'(out_dst), e);
                    if (e >= 0) exp_mask[e] = 1'b0;
                    pend[out_dst] = 1'b1;
                    nmsg++;
                end else begin
                    chk(int'(out_kind) == (wr ? 3 : 2), wr ? "R4" : "R2", "reply kind", int'(out_kind), wr ? 3 : 2);
                    chk(int'(out_dst) == src, "R2", "reply target", int'(out_dst), src);
                    chk(pend == 0 && exp_mask == 0, "R4", "reply before responses", int'({pend, exp_mask}), 0);
                    dtag = wr ? (had_wb ? "R8" : "R4") : (was_dirty ? "R6" : "R2");
                    chk(out_data == m_mem[blk], dtag, "reply data", int'(out_data), int'(m_mem[blk]));
                    done = 1;
                end
            end
            if (hs_r) begin
                pend[rsp_src] = 1'b0;
                if (rsp_wb) begin
                    m_mem[blk] = rsp_data;
                    had_wb = 1;
                end
            end
            @(posedge clk); #1;
            if (hs_r || !rsp_valid) begin
                rsp_valid = 0;
                if (pend != 0 && ($urandom % 2) == 0) begin
                    int r = lowest(pend);
                    rsp_valid = 1;
                    rsp_src = 2'(r);
                    rsp_wb = was_dirty && (r == owner);
                    rsp_data = m_cval[r][blk];
                end
            end
            out_ready = ($urandom % 4) != 0;
            if (cycles > 400) begin
                chk(0, "R4", "watchdog expired", cycles, 400);
                done = 1;
            end
        end
        chk(!stall_bad, "R7", "request taken mid-transaction", int'(stall_bad), 0);
        if (wr) begin
            m_pres[blk] = 4'(1) << src;
            m_dirty[blk] = 1;
            m_cval[src][blk] = 8'($urandom);
        end else begin
            m_pres[blk] |= 4'(1) << src;
            m_dirty[blk] = 0;
        end
        last_nmsg = nmsg;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < NB; b++) begin
            m_pres[b] = 0; m_dirty[b] = 0; m_mem[b] = 8'(b);
            for (int p = 0; p < NP; p++) m_cval[p][b] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(rsp_ready == 0, "R9", "rsp_ready after reset", int'(rsp_ready), 0);
        // R1/R2: clean reads return the preset word; sharers build up.
        run_req(0, 0, 3);
        run_req(1, 0, 3);
        run_req(2, 0, 3);
        // R3/R4: sharer 1 writes; 0 and 2 are invalidated in order, not 1.
        run_req(1, 1, 3);
        chk(last_nmsg == 2, "R3", "invalidations sent", last_nmsg, 2);
        // R5/R6: read to the dirty block reaches only the writer.
        run_req(3, 0, 3);
        chk(last_nmsg == 1, "R5", "fetches after grant", last_nmsg, 1);
        run_req(2, 1, 3);
        // R8: a write to a block owned dirty by another takes the written-back word.
        run_req(0, 1, 3);
        // R5: the owner writes again with no invalidations.
        run_req(0, 1, 3);
        chk(last_nmsg == 0, "R5", "messages on owner rewrite", last_nmsg, 0);
        // All four share a block, then one writes.
        for (int p = 0; p < NP; p++) run_req(p, 0, 5);
        run_req(3, 1, 5);
        chk(last_nmsg == 3, "R3", "invalidations of full share", last_nmsg, 3);
        @(negedge clk);
        chk(rsp_ready == 0, "R9", "rsp_ready when idle", int'(rsp_ready), 0);
        for (int i = 0; i < 400; i++) run_req(int'($urandom % 4), bit'($urandom % 2), int'($urandom % 4));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL R7 global watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule